// File: doc/BRIEF.md
# Pipeline Valid-Bit Stall and Flush Controller

This block is the sequencing control for the interstage registers and the fetch address of a five-stage pipeline: fetch, address computation, operand fetch, operate and operand store. Each of the four interstage registers carries a valid flag. The block gives each register a load enable. When a stage is locked, that stage and everything upstream of it freeze, and an invalid entry (a bubble) goes into the register just below the frozen section. Stages further down keep moving.

A taken branch comes from the instruction in the operand store stage. It overrides any lock, clears every valid flag and loads the branch target into the fetch address. A skip comes from the operate stage. It invalidates only the next real instruction behind the skipping one and leaves the fetch address alone. If that next instruction has not been fetched yet, the kill is remembered until it arrives. Per-stage resource requests from the datapath are masked with the valid flag of their stage.

Top module: `pvc_flow_ctrl`

## Requirements
- R1: While reset is asserted and right after it, every valid flag is 0 and the fetch address is 0.
- R2: In a cycle with no lock and no taken branch, the fetch address increases by 1 (wrapping at its width). Register 0 takes a valid entry, unless a skip kill is pending. Each register k>0 takes the flag of register k-1.
- R3: A lock on a stage holds that stage's input register and all lower-numbered registers, with their load enables at 0 and their valid flags kept. The fetch address holds while any lock is raised. The address lock freezes register 0 (the input of address computation). The operand lock freezes registers 0 and 1.
- R4: The register just below the deepest frozen register receives valid 0. Registers below it advance normally.
- R5: When both locks are raised together, the operand lock sets the frozen depth.
- R6: A branch request while register 3 (the operand store entry) is valid clears all four valid flags on the next edge and loads the branch target into the fetch address. This holds even while locks are raised.
- R7: A branch request while register 3 is invalid has no effect.
- R8: A skip request while register 2 (the operate entry) is valid and no branch is taken clears the valid flag of the highest-numbered valid register below 2. No other flag is touched and the fetch address is unaffected.
- R9: If no register below 2 is valid when a skip fires, the next entry loaded into register 0 from fetch enters invalid. A taken branch cancels this pending kill.
- R10: A skip request while register 2 is invalid has no effect.
- R11: Each gated request output equals the raw request of its register ANDed with that register's valid flag.
- R12: In a cycle with a taken branch, all load enables are 1. Otherwise the load enable of register k is 1 exactly when register k is not frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ad_lock | input | 1 | Freeze the address computation stage and everything upstream |
| op_lock | input | 1 | Freeze the operand fetch stage and everything upstream |
| br_req | input | 1 | Branch request from the operand store stage |
| br_target | input | ADDR_W | Branch destination address |
| skip_req | input | 1 | Skip request from the operate stage |
| req_raw | input | NREG | Raw per-register resource requests |
| stage_load | output | NREG | Load enable of each interstage register |
| stage_valid | output | NREG | Valid flag of each interstage register |
| fetch_addr | output | ADDR_W | Current fetch address |
| req_gated | output | NREG | Requests masked by valid |

## Verification
The hardest case to reach from the ports is a skip that finds no valid entry behind it, so that the kill has to wait for a fetch that a lock may still be holding back. A branch is the only thing that can cancel such a wait. To get there, the stimulus uses a long pseudo-random run with frequent branches, which empty the pipe, and dense skip and lock requests. A bench-side reference model updates alongside the design, and every output is compared on every cycle.

// File: rtl/pvc_pkg.sv
package pvc_pkg;
  typedef enum logic [1:0] {
    FA_SEQ  = 2'd0,
    FA_HOLD = 2'd1,
    FA_JUMP = 2'd2
  } fa_cause_e;

  function automatic fa_cause_e pick_cause(input logic take, input logic frozen);
    if (take) return FA_JUMP;
    if (frozen) return FA_HOLD;
    return FA_SEQ;
  endfunction

  function automatic logic frozen_at(input int k, input logic ad, input logic op,
                                     input int ad_idx, input int op_idx);
    return (ad && (k <= ad_idx)) || (op && (k <= op_idx));
  endfunction
endpackage

// File: rtl/pvc_hold_ctl.sv
module pvc_hold_ctl #(
  parameter int NREG   = 4,
  parameter int AD_IDX = 0,
  parameter int OP_IDX = 1
) (
  input  logic            ad_lock,
  input  logic            op_lock,
  output logic [NREG-1:0] hold_mask,
  output logic [NREG-1:0] bubble_mask,
  output logic            lock_any
);
  import pvc_pkg::*;

  for (genvar k = 0; k < NREG; k++) begin : g_hold
    assign hold_mask[k] = frozen_at(k, ad_lock, op_lock, AD_IDX, OP_IDX);
    if (k == 0) begin : g_top
      assign bubble_mask[k] = 1'b0;
    end else begin : g_rest
      assign bubble_mask[k] = hold_mask[k-1] & ~hold_mask[k];
    end
  end

  assign lock_any = ad_lock | op_lock;
endmodule

// File: rtl/pvc_skip_sel.sv
module pvc_skip_sel #(
  parameter int NREG     = 4,
  parameter int SKIP_IDX = 2
) (
  input  logic              skip_req,
  input  logic              take,
  input  logic              skipper_held,
  input  logic [SKIP_IDX:0] vld_up,
  output logic [NREG-1:0]   kill_mask,
  output logic              kill_fetch,
  output logic              skip_fire
);
  logic found;

  assign skip_fire = skip_req & vld_up[SKIP_IDX] & ~take & ~skipper_held;

  always_comb begin
    kill_mask = '0;
    found     = 1'b0;
    for (int j = SKIP_IDX - 1; j >= 0; j--) begin
      if (!found && vld_up[j]) begin
        found        = 1'b1;
        kill_mask[j] = skip_fire;
      end
    end
    kill_fetch = skip_fire & ~found;
  end
endmodule

// File: rtl/pvc_valid_chain.sv
module pvc_valid_chain #(
  parameter int NREG = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic [NREG-1:0] hold_mask,
  input  logic [NREG-1:0] bubble_mask,
  input  logic [NREG-1:0] kill_mask,
  input  logic            kill_fetch,
  output logic [NREG-1:0] vld,
  output logic [NREG-1:0] load
);
  logic [NREG-1:0] vld_eff;
  logic [NREG-1:0] vld_nxt;
  logic            pend_q;
  logic            pend_eff;

  assign vld_eff  = vld & ~kill_mask;
  assign pend_eff = pend_q | kill_fetch;

  for (genvar k = 0; k < NREG; k++) begin : g_stage
    assign load[k] = take | ~hold_mask[k];
    if (k == 0) begin : g_entry
      always_comb begin
        if (take)              vld_nxt[k] = 1'b0;
        else if (hold_mask[k]) vld_nxt[k] = vld_eff[k];
        else                   vld_nxt[k] = ~pend_eff;
      end
    end else begin : g_body
      always_comb begin
        if (take)                vld_nxt[k] = 1'b0;
        else if (hold_mask[k])   vld_nxt[k] = vld_eff[k];
        else if (bubble_mask[k]) vld_nxt[k] = 1'b0;
        else                     vld_nxt[k] = vld_eff[k-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld    <= '0;
      pend_q <= 1'b0;
    end else begin
      vld    <= vld_nxt;
      pend_q <= take ? 1'b0 : (hold_mask[0] ? pend_eff : 1'b0);
    end
  end
endmodule

// File: rtl/pvc_pc.sv
module pvc_pc #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              frozen,
  input  logic [ADDR_W-1:0] target,
  output logic [ADDR_W-1:0] pc
);
  import pvc_pkg::*;

  fa_cause_e cause;

  function automatic logic [ADDR_W-1:0] next_pc(input fa_cause_e c,
                                                input logic [ADDR_W-1:0] cur,
                                                input logic [ADDR_W-1:0] tgt);
    case (c)
      FA_JUMP: return tgt;
      FA_HOLD: return cur;
      default: return cur + 1'b1;
    endcase
  endfunction

  assign cause = pick_cause(take, frozen);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc <= '0;
    else        pc <= next_pc(cause, pc, target);
  end
endmodule

// File: rtl/pvc_flow_ctrl.sv
module pvc_flow_ctrl #(
  parameter int ADDR_W   = 8,
  parameter int NREG     = 4,
  parameter int AD_IDX   = 0,
  parameter int OP_IDX   = 1,
  parameter int SKIP_IDX = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ad_lock,
  input  logic              op_lock,
  input  logic              br_req,
  input  logic [ADDR_W-1:0] br_target,
  input  logic              skip_req,
  input  logic [NREG-1:0]   req_raw,
  output logic [NREG-1:0]   stage_load,
  output logic [NREG-1:0]   stage_valid,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic [NREG-1:0]   req_gated
);
  localparam int LAST = NREG - 1;

  logic [NREG-1:0] hold_mask;
  logic [NREG-1:0] bubble_mask;
  logic [NREG-1:0] kill_mask;
  logic            lock_any;
  logic            kill_fetch;
  logic            skip_fire;
  logic            br_take;

  assign br_take = br_req & stage_valid[LAST];

  pvc_hold_ctl #(.NREG(NREG), .AD_IDX(AD_IDX), .OP_IDX(OP_IDX)) hold_i (
    .ad_lock(ad_lock), .op_lock(op_lock),
    .hold_mask(hold_mask), .bubble_mask(bubble_mask), .lock_any(lock_any)
  );

  pvc_skip_sel #(.NREG(NREG), .SKIP_IDX(SKIP_IDX)) skip_i (
    .skip_req(skip_req), .take(br_take), .skipper_held(hold_mask[SKIP_IDX]),
    .vld_up(stage_valid[SKIP_IDX:0]),
    .kill_mask(kill_mask), .kill_fetch(kill_fetch), .skip_fire(skip_fire)
  );

  pvc_valid_chain #(.NREG(NREG)) chain_i (
    .clk(clk), .rst_n(rst_n), .take(br_take),
    .hold_mask(hold_mask), .bubble_mask(bubble_mask),
    .kill_mask(kill_mask), .kill_fetch(kill_fetch),
    .vld(stage_valid), .load(stage_load)
  );

  pvc_pc #(.ADDR_W(ADDR_W)) pc_i (
    .clk(clk), .rst_n(rst_n), .take(br_take), .frozen(lock_any),
    .target(br_target), .pc(fetch_addr)
  );

  for (genvar k = 0; k < NREG; k++) begin : g_gate
    assign req_gated[k] = req_raw[k] & stage_valid[k];
  end
endmodule

// File: rtl/pvc_flow_ctrl_chk.sv
module pvc_flow_ctrl_chk #(
  parameter int ADDR_W = 8,
  parameter int NREG   = 4,
  parameter int AD_IDX = 0,
  parameter int OP_IDX = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ad_lock,
  input logic              op_lock,
  input logic              br_req,
  input logic [ADDR_W-1:0] br_target,
  input logic [NREG-1:0]   stage_load,
  input logic [NREG-1:0]   stage_valid,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              br_take,
  input logic              lock_any
);
  assert_flush_R6: assert property (@(posedge clk) disable iff (!rst_n)
    br_take |=> (stage_valid == '0) && (fetch_addr == $past(br_target)));

  assert_pc_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!br_take && lock_any) |=> $stable(fetch_addr));

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!br_take && !lock_any) |=> fetch_addr == ADDR_W'($past(fetch_addr) + 1'b1));

  assert_bubble_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!br_take && ad_lock && !op_lock) |=> !stage_valid[AD_IDX+1]);

  assert_bubble_op_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!br_take && op_lock) |=> !stage_valid[OP_IDX+1]);

  assert_load_all_R12: assert property (@(posedge clk) disable iff (!rst_n)
    br_take |-> (&stage_load));

  assert_no_branch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (br_req && !stage_valid[NREG-1] && !lock_any)
      |=> fetch_addr == ADDR_W'($past(fetch_addr) + 1'b1));
endmodule

bind pvc_flow_ctrl pvc_flow_ctrl_chk #(
  .ADDR_W(ADDR_W), .NREG(NREG), .AD_IDX(AD_IDX), .OP_IDX(OP_IDX)
) chk_i (
  .clk(clk), .rst_n(rst_n), .ad_lock(ad_lock), .op_lock(op_lock),
  .br_req(br_req), .br_target(br_target), .stage_load(stage_load),
  .stage_valid(stage_valid), .fetch_addr(fetch_addr),
  .br_take(br_take), .lock_any(lock_any)
);

// File: tb/pvc_flow_ctrl_tb_top.sv
`timescale 1ns/1ps
module pvc_flow_ctrl_tb_top;
  localparam int AW = 8;
  localparam int NR = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ad_lock, op_lock, br_req, skip_req;
  logic [AW-1:0] br_target;
  logic [NR-1:0] req_raw;
  logic [NR-1:0] stage_load, stage_valid, req_gated;
  logic [AW-1:0] fetch_addr;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  pvc_flow_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .ad_lock(ad_lock), .op_lock(op_lock),
    .br_req(br_req), .br_target(br_target), .skip_req(skip_req),
    .req_raw(req_raw), .stage_load(stage_load), .stage_valid(stage_valid),
    .fetch_addr(fetch_addr), .req_gated(req_gated)
  );

  // reference state
  logic [NR-1:0] mv;
  logic [AW-1:0] mpc;
  bit            mpend;
  string         vtag, ptag;
  logic [31:0]   rng = 32'h1BADF00D;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    int depth;
    bit take;
    logic [NR-1:0] eload;
    take  = br_req && mv[3];
    depth = op_lock ? 2 : (ad_lock ? 1 : 0);
    for (int k = 0; k < NR; k++) eload[k] = take || (k >= depth);
    check(stage_valid === mv, vtag, "valid", 32'(stage_valid), 32'(mv));
    check(fetch_addr === mpc, ptag, "fetch_addr", 32'(fetch_addr), 32'(mpc));
    check(stage_load === eload, take ? "R12" : "R3", "load", 32'(stage_load), 32'(eload));
    check(req_gated === (req_raw & mv), "R11", "gated", 32'(req_gated), 32'(req_raw & mv));
  endtask

  task automatic model_step();
    int depth, tgt;
    bit take, fire;
    logic [NR-1:0] v, nv;
    bit pe;
    take  = br_req && mv[3];
    depth = op_lock ? 2 : (ad_lock ? 1 : 0);
    fire  = skip_req && mv[2] && !take;
    tgt   = -1;
    if (fire) tgt = mv[1] ? 1 : (mv[0] ? 0 : -1);
    if (take) vtag = "R6";
    else if (br_req) vtag = "R7";
    else if (fire) vtag = (tgt < 0) ? "R9" : "R8";
    else if (skip_req) vtag = "R10";
    else if (ad_lock && op_lock) vtag = "R5";
    else if (depth > 0) vtag = "R4";
    else vtag = "R2";
    ptag = take ? "R6" : (br_req ? "R7" : (depth > 0 ? "R3" : "R2"));
    if (take) begin
      mv = '0; mpc = br_target; mpend = 0;
      return;
    end
    v = mv;
    if (tgt >= 0) v[tgt] = 1'b0;
    pe = mpend || (fire && tgt < 0);
    for (int k = 0; k < NR; k++) begin
      if (k < depth)       nv[k] = v[k];
      else if (k == 0)     nv[k] = !pe;
      else if (k == depth) nv[k] = 1'b0;
      else                 nv[k] = v[k-1];
    end
    mpend = (depth > 0) ? pe : 0;
    mv    = nv;
    if (depth == 0) mpc = mpc + 1;
  endtask

  function automatic logic [31:0] xs(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    return y ^ (y << 5);
  endfunction

  initial begin
    rst_n = 0; ad_lock = 0; op_lock = 0; br_req = 0; skip_req = 0;
    br_target = '0; req_raw = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(stage_valid === '0, "R1", "reset valid", 32'(stage_valid), 0);
    check(fetch_addr === '0, "R1", "reset pc", 32'(fetch_addr), 0);
    rst_n = 1;
    mv = '0; mpc = '0; mpend = 0; vtag = "R1"; ptag = "R1";
    for (int c = 0; c < 6000; c++) begin
      if (c >= 6) begin
        rng = xs(rng);
        ad_lock   = (rng[1:0] == 2'b00);
        op_lock   = (rng[3:2] == 2'b00);
        br_req    = (rng[6:4] == 3'b000);
        br_target = rng[15:8];
        skip_req  = rng[17] | rng[18];
        req_raw   = rng[23:20];
      end
      #1;
      compare_all();
      if (c == 6) begin
        check(fetch_addr === AW'(6), "R2", "pc after idle", 32'(fetch_addr), 6);
        check(stage_valid === 4'b1111, "R2", "full pipe", 32'(stage_valid), 32'hF);
      end
      model_step();
      @(negedge clk);
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule